// File: doc/BRIEF.md
# Manchester Packet Receiver with Start-Flag Framing

This block takes the digitised output of an optical comparator, a Manchester-coded serial stream with roughly nine system clocks per bit, and turns it into bytes. Timing is recovered entirely in sequential logic. The input passes through a two-flop synchroniser and an edge detector. After each accepted mid-bit transition, a blanking counter ignores any further transition for three quarters of a nominal bit period. This rejects the transitions at bit boundaries and re-locks on every bit, so the block adapts at once to drift in the sender's rate.

Each accepted transition shifts one decoded bit into a twelve-bit serial-in, parallel-out register. When the oldest four bits equal the start flag, the eight younger bits are copied into a holding register. A one-cycle new-byte pulse is raised at the same time, and the shift register is cleared. The holding register survives a drop of the receiver enable, so the controller can read the last byte after the front end has been powered down.

Top module: `manchester_frame_rx`

## Requirements
- R1: After reset, `dataOut` is 0 and `newByte` is 0.
- R2: A falling mid-bit transition decodes as 1 and a rising one as 0. A frame is one or more bits, then the start flag (default 1010, sent left to right), then 8 data bits sent most significant first. It loads `dataOut` with the data byte, so the first data bit received lands in bit 7. `dataOut` changes only in a cycle where `newByte` is high.
- R3: `newByte` is high for exactly one cycle. It rises on the fourth rising clock edge after the mid-bit transition of the last data bit appears on `rxIn`.
- R4: After an accepted transition, transitions less than 6 clocks later (3/4 of the 9-clock nominal bit) are ignored. Frames with bit periods of 8, 9 or 10 clocks, and with periods varying between 8 and 10 within a frame, decode correctly.
- R5: A frame whose first four bits differ from the start flag produces no `newByte` and leaves `dataOut` unchanged.
- R6: While `rxEn` is low, the stream is ignored, `newByte` stays 0 and `dataOut` keeps the last captured byte.
- R7: After a capture the shift register restarts empty. Bits that follow a captured frame cannot re-use its data bits as a start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about 9 clocks per Manchester bit |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEn | input | 1 | Receiver enable; low clears the recovery state but keeps the held byte |
| rxIn | input | 1 | Raw comparator output, asynchronous |
| dataOut | output | 8 | Last captured payload byte |
| newByte | output | 1 | One-cycle pulse when `dataOut` is loaded |

## Verification
The assertions take for granted that consecutive mid-bit transitions are at least 6 clocks apart, and that boundary transitions fall fewer than 6 clocks after a mid-bit transition. This means every bit period stays between 8 and 10 clocks. The stimulus keeps `rxIn` low whenever `rxEn` rises, and opens each burst with a zero bit, so the first transition seen is a mid-bit one. It also holds the enable for at least a dozen clocks after the last transition of a burst, so a pending capture is never cut off. All frames, including jittered ones, are generated inside that 8-to-10-clock window.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef struct packed {
    logic shift;   // push one decoded bit
    logic bitVal;  // value of that bit
    logic capture; // copy payload to holding register
    logic clear;   // empty the shift register
  } rxStrobe_t;
endpackage

// File: rtl/mrx_ctrl.sv
module mrx_ctrl #(
  parameter int NOM_CLKS = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEn,
  input  logic               rxIn,
  input  logic               flagHit,
  output mrx_pkg::rxStrobe_t strb
);
  localparam int BLANK   = (3 * NOM_CLKS) / 4;
  localparam int CNT_MAX = 2 * NOM_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  // [0],[1]: synchroniser; [2]: previous level for edge detection
  logic [2:0]       syncQ;
  logic [CNT_W-1:0] sinceEdge;
  logic             edgeSeen;
  logic             accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      syncQ <= '0;
    else if (!rxEn) syncQ <= '0;
    else            syncQ <= {syncQ[1:0], rxIn};
  end

  assign edgeSeen = syncQ[2] ^ syncQ[1];
  assign accept   = rxEn && edgeSeen && (sinceEdge >= BLANK_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceEdge <= MAX_C;
    else if (!rxEn)             sinceEdge <= MAX_C;
    else if (accept)            sinceEdge <= ONE_C;
    else if (sinceEdge != MAX_C) sinceEdge <= sinceEdge + ONE_C;
  end

  always_comb begin
    strb.shift   = accept;
    strb.bitVal  = syncQ[2];          // level before a falling edge is 1
    strb.capture = rxEn && flagHit;
    strb.clear   = !rxEn || strb.capture;
  end
endmodule

// File: rtl/mrx_dpath.sv
module mrx_dpath #(
  parameter int                 FLAG_W = 4,
  parameter int                 DATA_W = 8,
  parameter logic [FLAG_W-1:0]  FLAG   = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  mrx_pkg::rxStrobe_t strb,
  output logic               flagHit,
  output logic [DATA_W-1:0]  dataOut,
  output logic               newByte
);
  localparam int SR_W = FLAG_W + DATA_W;

  logic [SR_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftQ <= '0;
    else if (strb.clear)  shiftQ <= '0;
    else if (strb.shift)  shiftQ <= {shiftQ[SR_W-2:0], strb.bitVal};
  end

  assign flagHit = (shiftQ[SR_W-1 -: FLAG_W] == FLAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      newByte <= 1'b0;
    end else begin
      newByte <= strb.capture;
      if (strb.capture) dataOut <= shiftQ[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/manchester_frame_rx.sv
module manchester_frame_rx #(
  parameter int                NOM_CLKS = 9,
  parameter int                FLAG_W   = 4,
  parameter int                DATA_W   = 8,
  parameter logic [FLAG_W-1:0] FLAG     = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              newByte
);
  mrx_pkg::rxStrobe_t strb;
  logic               flagHit;

  mrx_ctrl #(.NOM_CLKS(NOM_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxIn(rxIn),
    .flagHit(flagHit), .strb(strb)
  );

  mrx_dpath #(.FLAG_W(FLAG_W), .DATA_W(DATA_W), .FLAG(FLAG)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .flagHit(flagHit), .dataOut(dataOut), .newByte(newByte)
  );
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker #(
  parameter int NOM_CLKS = 9,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEn,
  input logic [DATA_W-1:0] dataOut,
  input logic              newByte,
  input logic              shiftStb
);
  localparam int BLANK = (3 * NOM_CLKS) / 4;
  localparam int GAP_W = $clog2(BLANK + 1);
  localparam logic [GAP_W-1:0] SAT_C = GAP_W'(BLANK);

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gapCnt <= SAT_C;
    else if (!rxEn)          gapCnt <= SAT_C;
    else if (shiftStb)       gapCnt <= GAP_W'(1);
    else if (gapCnt != SAT_C) gapCnt <= gapCnt + GAP_W'(1);
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    newByte |=> !newByte);

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !newByte);

  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> $stable(dataOut));

  p_data_moves_with_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> newByte);

  p_blank_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    shiftStb |-> (gapCnt >= SAT_C));
endmodule

bind manchester_frame_rx mrx_checker #(.NOM_CLKS(NOM_CLKS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxEn(rxEn), .dataOut(dataOut),
  .newByte(newByte), .shiftStb(strb.shift)
);

// File: tb/test_manchester_frame_rx.sv
module test_manchester_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] SFLAG = 4'b1010;
  localparam int WD_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEn = 1'b0;
  logic rxIn = 1'b0;
  logic [7:0] dataOut;
  logic newByte;

  manchester_frame_rx i_manchester_frame_rx (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxIn(rxIn),
    .dataOut(dataOut), .newByte(newByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int nChecks = 0;
  int nFail = 0;
  int pulses = 0;
  bit monOn = 0;
  bit en = 0;
  int mdl = 0;
  int expCycQ[$];
  logic [7:0] expByteQ[$];
  logic [7:0] expData = 8'h00;
  logic expNew;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference: 12-bit window after clear, match on oldest four
  task automatic modelBit(input bit b);
    if (en) begin
      mdl = ((mdl << 1) | int'(b)) & 'hFFF;
      if (((mdl >> 8) & 'hF) == int'(SFLAG)) begin
        expCycQ.push_back(cyc + 4);
        expByteQ.push_back(8'(mdl & 'hFF));
        mdl = 0;
      end
    end
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      expNew = 1'b0;
      if (expCycQ.size() > 0 && expCycQ[0] == cyc) begin
        expNew  = 1'b1;
        expData = expByteQ[0];
        void'(expCycQ.pop_front());
        void'(expByteQ.pop_front());
      end
      check(newByte === expNew, "R3 newByte timing", int'(newByte), int'(expNew));
      check(dataOut === expData, "R2 dataOut value", int'(dataOut), int'(expData));
      if (newByte === 1'b1) pulses++;
    end
  end

  task automatic sendBit(input bit b, input int per);
    int h1;
    h1 = per / 2;
    @(negedge clk) rxIn = b;
    repeat (h1 - 1) @(negedge clk);
    @(negedge clk) begin
      rxIn = ~b;
      modelBit(b);
    end
    repeat (per - h1 - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [3:0] flg, input logic [7:0] byt,
                           input int per, input bit jit);
    int p;
    sendBit(1'b0, per);
    for (int i = 3; i >= 0; i--) sendBit(flg[i], per);
    for (int i = 7; i >= 0; i--) begin
      p = jit ? per + (i % 3) - 1 : per;
      sendBit(byt[i], p);
    end
  endtask

  task automatic endBurst();
    repeat (12) @(negedge clk);
    @(negedge clk) begin rxEn = 1'b0; en = 0; end
    @(negedge clk) rxIn = 1'b0;
    mdl = 0;
    repeat (4) @(negedge clk);
    @(negedge clk) begin rxEn = 1'b1; en = 1; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_CYCLES);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int p0;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(dataOut === 8'h00, "R1 reset dataOut", int'(dataOut), 0);
    check(newByte === 1'b0, "R1 reset newByte", int'(newByte), 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk) monOn = 1;
    check(dataOut === 8'h00, "R1 dataOut after reset release", int'(dataOut), 0);
    @(negedge clk) begin rxEn = 1'b1; en = 1; end
    repeat (4) @(negedge clk);

    // R2: basic frame
    p0 = pulses;
    sendFrame(SFLAG, 8'hA5, 9, 0);
    endBurst();
    check(pulses - p0 == 1, "R3 one pulse per frame", pulses - p0, 1);
    check(dataOut === 8'hA5, "R2 byte A5", int'(dataOut), 'hA5);

    // R4: rate spread, all-same bits (boundary edges every bit)
    sendFrame(SFLAG, 8'h3C, 8, 0);  endBurst();
    check(dataOut === 8'h3C, "R4 period 8", int'(dataOut), 'h3C);
    sendFrame(SFLAG, 8'hC3, 10, 0); endBurst();
    check(dataOut === 8'hC3, "R4 period 10", int'(dataOut), 'hC3);
    sendFrame(SFLAG, 8'h96, 9, 1);  endBurst();
    check(dataOut === 8'h96, "R4 jittered 8..10", int'(dataOut), 'h96);
    sendFrame(SFLAG, 8'hFF, 8, 0);  endBurst();
    check(dataOut === 8'hFF, "R4 all ones", int'(dataOut), 'hFF);
    sendFrame(SFLAG, 8'h00, 10, 0); endBurst();
    check(dataOut === 8'h00, "R4 all zeros", int'(dataOut), 0);
    sendFrame(SFLAG, 8'h5A, 9, 0);  endBurst();
    check(dataOut === 8'h5A, "R2 byte 5A", int'(dataOut), 'h5A);

    // R5: wrong start flag
    p0 = pulses;
    held = dataOut;
    sendFrame(4'b1100, 8'h5A, 9, 0);
    endBurst();
    check(pulses - p0 == 0, "R5 no pulse on bad flag", pulses - p0, 0);
    check(dataOut === held, "R5 dataOut kept", int'(dataOut), int'(held));

    // R6: receiver disabled
    @(negedge clk) begin rxEn = 1'b0; en = 0; end
    p0 = pulses;
    sendFrame(SFLAG, 8'h11, 9, 0);
    check(dataOut === held, "R6 byte held while off", int'(dataOut), int'(held));
    endBurst();
    check(pulses - p0 == 0, "R6 no pulse while off", pulses - p0, 0);
    check(dataOut === held, "R6 byte held after off", int'(dataOut), int'(held));

    // R7: payload holding a flag pattern, then four more bits
    p0 = pulses;
    sendFrame(SFLAG, 8'b1010_0110, 9, 0);
    sendBit(1'b0, 9); sendBit(1'b1, 9); sendBit(1'b1, 9); sendBit(1'b0, 9);
    endBurst();
    check(pulses - p0 == 1, "R7 no re-match after capture", pulses - p0, 1);
    check(dataOut === 8'hA6, "R7 captured byte", int'(dataOut), 'hA6);

    sendFrame(SFLAG, 8'h69, 9, 1);
    endBurst();
    check(dataOut === 8'h69, "R2 final frame", int'(dataOut), 'h69);
    check(expCycQ.size() == 0, "R3 all expected pulses seen", expCycQ.size(), 0);

    monOn = 0;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule